// File: doc/BRIEF.md
# Potentiometer Command Front End with Busy Polling

This block is the serial slave front end of a dual digitally controlled potentiometer. It watches a two-wire bus (clock line and open-drain data line), detects start and stop conditions, shifts in bytes most significant bit first, and answers with an acknowledge. The first byte after a start names the device. It is accepted only when its upper nibble holds the fixed device-type code and its lower nibble equals the four external address pins. The second byte is an instruction. It is decoded into an opcode, a data-register pointer and a wiper select, and these are presented together with a one-cycle strobe. Any further bytes are data bytes, and each one is acknowledged.

When a nonvolatile write command ends with a stop on a byte boundary, the block starts an internal write timer. While that timer runs, the block ignores the bus completely and does not acknowledge even its own address. A bus master can therefore poll for completion by sending a start and the address byte until an acknowledge comes back.

Top module: `pot_cmd_slave`

## Requirements
- R1: After reset, the data-line pull is released, busy is low and no command strobe is issued.
- R2: An identification byte whose bits [7:4] equal 4'b0101 and whose bits [3:0] equal the address pins is acknowledged. The block pulls SDA low from the SCL falling edge after the eighth bit until the SCL falling edge that ends the ninth clock. The pull changes only while SCL is low.
- R3: An identification byte whose device code or address differs gets no acknowledge. No byte of that transfer is acknowledged and no strobe is issued until the next start.
- R4: The instruction byte is acknowledged and decoded as follows: opcode = bits [7:4], register pointer = bits [3:2] (00 to 11 select registers 0 to 3), wiper select = bit [0]. Bit [1] is ignored. The fields are valid with a single-cycle strobe.
- R5: Every data byte that follows an accepted instruction byte is acknowledged.
- R6: A stop that follows at least one complete data byte of a command with opcode NV_WR_OP (default 4'b1100) raises busy for exactly WR_CYCLES clock cycles.
- R7: While busy, a start followed by a matching identification byte gets no acknowledge and no strobe is issued. After busy falls, the same sequence is acknowledged.
- R8: A start or stop in the middle of a byte aborts the command. It issues no strobe and starts no write cycle.
- R9: A stop after a command with any other opcode, or after a nonvolatile write opcode with no complete data byte, leaves busy low.
- R10: Bytes are assembled most significant bit first from SDA sampled at SCL rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_pins_i | input | 4 | External slave address pins |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain acknowledge) |
| cmd_valid_o | output | 1 | One-cycle strobe for a decoded instruction |
| cmd_opcode_o | output | 4 | Decoded instruction opcode |
| cmd_reg_o | output | 2 | Decoded data-register pointer |
| cmd_wiper_o | output | 1 | Decoded wiper select |
| busy_o | output | 1 | Internal nonvolatile write cycle in progress |

## Verification
The bench sets WR_CYCLES to 1500 instead of the default of several milliseconds' worth of cycles. It drives SCL with a quarter period of 8 clocks. A poll sent immediately after the qualifying stop therefore finishes its address byte while the timer is still running. A full busy window also fits easily in the run, so the exact busy length, the refused poll and the accepted poll afterwards can all be observed. NV_WR_OP keeps its default, which lets the random instruction bytes steer clear of that one opcode.

// File: rtl/pot_cmd_pkg.sv
package pot_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_CODE = 4'b0101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKW,
    ST_ACK,
    ST_IGNR
  } rx_state_t;

  typedef enum logic [1:0] {
    IDX_ID,
    IDX_INSTR,
    IDX_DATA,
    IDX_MORE
  } byte_idx_t;

  typedef struct packed {
    logic [3:0] opcode;
    logic [1:0] regsel;
    logic       wiper;
  } cmd_t;
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/bus_edge_detect.sv
module bus_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise_o = scl_s & ~scl_q;
    scl_fall_o = ~scl_s & scl_q;
    start_o    = scl_s & scl_q & sda_q & ~sda_s;
    stop_o     = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
  import pot_cmd_pkg::*;
#(
  parameter logic [3:0] NV_WR_OP = 4'b1100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_s_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [3:0] addr_pins_i,
  output logic       ack_drv_o,
  output logic       cmd_valid_o,
  output cmd_t       cmd_o,
  output logic       nv_go_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  rx_state_t          st_q, st_n;
  byte_idx_t          idx_q, idx_n;
  logic [CNT_W-1:0]   bit_q, bit_n;
  logic [BYTE_W-1:0]  sh_q, sh_n, rx_byte;
  logic               ack_n, nvp_q, nvp_n, cv_n, go_n;
  cmd_t               cmd_n;

  always_comb begin
    st_n    = st_q;
    idx_n   = idx_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    ack_n   = ack_drv_o;
    nvp_n   = nvp_q;
    cmd_n   = cmd_o;
    cv_n    = 1'b0;
    go_n    = 1'b0;
    rx_byte = {sh_q[BYTE_W-2:0], sda_s_i};
    if (hold_i) begin
      st_n  = ST_IDLE;
      ack_n = 1'b0;
      nvp_n = 1'b0;
    end else if (start_i) begin
      st_n  = ST_RX;
      idx_n = IDX_ID;
      bit_n = '0;
      ack_n = 1'b0;
      nvp_n = 1'b0;
    end else if (stop_i) begin
      // a stop looks like one clocked bit after the acknowledge
      if (st_q == ST_RX && idx_q == IDX_MORE && bit_q == CNT_W'(1) && nvp_q)
        go_n = 1'b1;
      st_n  = ST_IDLE;
      ack_n = 1'b0;
      nvp_n = 1'b0;
    end else begin
      case (st_q)
        ST_RX: if (scl_rise_i) begin
          sh_n  = rx_byte;
          bit_n = bit_q + CNT_W'(1);
          if (bit_q == CNT_W'(BYTE_W - 1)) begin
            case (idx_q)
              IDX_ID: begin
                if (rx_byte == {DEV_CODE, addr_pins_i}) begin
                  st_n  = ST_ACKW;
                  idx_n = IDX_INSTR;
                end else begin
                  st_n = ST_IGNR;
                end
              end
              IDX_INSTR: begin
                st_n         = ST_ACKW;
                idx_n        = IDX_DATA;
                cv_n         = 1'b1;
                cmd_n.opcode = rx_byte[7:4];
                cmd_n.regsel = rx_byte[3:2];
                cmd_n.wiper  = rx_byte[0];
                nvp_n        = (rx_byte[7:4] == NV_WR_OP);
              end
              default: begin
                st_n  = ST_ACKW;
                idx_n = IDX_MORE;
              end
            endcase
          end
        end
        ST_ACKW: if (scl_fall_i) begin
          ack_n = 1'b1;
          st_n  = ST_ACK;
        end
        ST_ACK: if (scl_fall_i) begin
          ack_n = 1'b0;
          st_n  = ST_RX;
          bit_n = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      idx_q       <= IDX_ID;
      bit_q       <= '0;
      sh_q        <= '0;
      ack_drv_o   <= 1'b0;
      nvp_q       <= 1'b0;
      cmd_o       <= '0;
      cmd_valid_o <= 1'b0;
      nv_go_o     <= 1'b0;
    end else begin
      st_q        <= st_n;
      idx_q       <= idx_n;
      bit_q       <= bit_n;
      sh_q        <= sh_n;
      ack_drv_o   <= ack_n;
      nvp_q       <= nvp_n;
      cmd_o       <= cmd_n;
      cmd_valid_o <= cv_n;
      nv_go_o     <= go_n;
    end
  end
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int WR_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = go_i | (cnt_q != '0);
    cnt_n  = go_i ? CNT_W'(WR_CYCLES) : cnt_q - CNT_W'(1);
    busy_o = (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/pot_cmd_slave.sv
module pot_cmd_slave
  import pot_cmd_pkg::*;
#(
  parameter int         WR_CYCLES = 250000,
  parameter logic [3:0] NV_WR_OP  = 4'b1100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [3:0] addr_pins_i,
  output logic       sda_pull_o,
  output logic       cmd_valid_o,
  output logic [3:0] cmd_opcode_o,
  output logic [1:0] cmd_reg_o,
  output logic       cmd_wiper_o,
  output logic       busy_o
);
  logic [1:0] line_s;
  logic       scl_rise, scl_fall, start_ev, stop_ev, nv_go;
  cmd_t       cmd;

  sync2 #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  bus_edge_detect u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (line_s[1]),
    .sda_s      (line_s[0]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  cmd_fsm #(.NV_WR_OP(NV_WR_OP)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_i      (busy_o),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .sda_s_i     (line_s[0]),
    .start_i     (start_ev),
    .stop_i      (stop_ev),
    .addr_pins_i (addr_pins_i),
    .ack_drv_o   (sda_pull_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_o       (cmd),
    .nv_go_o     (nv_go)
  );

  busy_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (nv_go),
    .busy_o (busy_o)
  );

  assign cmd_opcode_o = cmd.opcode;
  assign cmd_reg_o    = cmd.regsel;
  assign cmd_wiper_o  = cmd.wiper;
endmodule

// File: rtl/pot_cmd_slave_chk.sv
module pot_cmd_slave_chk #(
  parameter int WR_CYCLES = 250000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_pull_o,
  input logic cmd_valid_o,
  input logic busy_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 32'd1;
    else             run_q <= '0;
  end

  // R1: no acknowledge pull straight out of reset
  assert_reset_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !sda_pull_o);

  // R2: the pull only changes while the clock line is low
  assert_pull_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  // R4: decode strobe lasts one cycle
  assert_strobe_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R6: busy window length
  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && run_q != 32'd0) |-> run_q == 32'(WR_CYCLES));

  // R7: no acknowledge while busy
  assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_pull_o);

  // R7: no strobe while busy
  assert_no_strobe_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !cmd_valid_o);
endmodule

bind pot_cmd_slave pot_cmd_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_i       (scl_i),
  .sda_pull_o  (sda_pull_o),
  .cmd_valid_o (cmd_valid_o),
  .busy_o      (busy_o)
);

// File: tb/pot_cmd_slave_test.sv
module pot_cmd_slave_test;
  localparam int WR = 1500;
  localparam int Q  = 8;

  logic       clk, rst_n, scl_m, sda_m;
  logic [3:0] pins;
  logic       sda_line;
  logic       sda_pull, cmd_valid, cmd_wiper, busy;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg;

  int checks = 0, fails = 0, strobes = 0, busy_cur = 0, busy_last = 0, busy_rises = 0;
  logic [3:0] last_op;
  logic [1:0] last_reg;
  logic       last_wiper, done = 1'b0, busy_prev = 1'b0;

  assign sda_line = sda_m & ~sda_pull;

  pot_cmd_slave #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_pins_i(pins), .sda_pull_o(sda_pull), .cmd_valid_o(cmd_valid),
    .cmd_opcode_o(cmd_op), .cmd_reg_o(cmd_reg), .cmd_wiper_o(cmd_wiper),
    .busy_o(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (cmd_valid) begin
      strobes++;
      last_op = cmd_op; last_reg = cmd_reg; last_wiper = cmd_wiper;
    end
    if (busy) busy_cur++;
    if (busy && !busy_prev) busy_rises++;
    if (!busy && busy_prev) begin busy_last = busy_cur; busy_cur = 0; end
    busy_prev = busy;
  end

  function automatic bit f_id_ok(logic [7:0] b, logic [3:0] p);
    return b[7:4] == 4'b0101 && b[3:0] == p;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    ack = !sda_line;
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic xfer(logic [7:0] id, logic [7:0] ins, int nd, logic [7:0] dat,
                      output bit a_id, output bit a_ins, output bit a_dat);
    bus_start;
    send_byte(id, a_id);
    send_byte(ins, a_ins);
    a_dat = 1'b0;
    for (int k = 0; k < nd; k++) send_byte(dat, a_dat);
    bus_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a1, a2, a3;
    int s0;
    void'($urandom(32'd4711));
    scl_m = 1'b1; sda_m = 1'b1; pins = 4'hA; rst_n = 1'b0;
    wq(5); rst_n = 1'b1; wq(5);

    chk("R1 pull", sda_pull, 0);
    chk("R1 busy", busy, 0);
    chk("R1 strobe", strobes, 0);

    // directed match; MSB-first decode of 0x9D
    s0 = strobes;
    xfer(8'h5A, 8'h9D, 1, 8'h33, a1, a2, a3);
    chk("R2 id ack", a1, 1);
    chk("R4 instr ack", a2, 1);
    chk("R5 data ack", a3, 1);
    chk("R4 strobe count", strobes - s0, 1);
    chk("R10 opcode", last_op, 9);
    chk("R4 regsel", last_reg, 3);
    chk("R4 wiper", last_wiper, 1);
    chk("R9 busy other op", busy, 0);

    // bit 1 ignored
    xfer(8'h5A, 8'h22, 2, 8'hA5, a1, a2, a3);
    chk("R4 op bit1", last_op, 2);
    chk("R4 reg bit1", last_reg, 0);
    chk("R4 wiper bit1", last_wiper, 0);
    chk("R5 second data ack", a3, 1);

    // mismatches
    s0 = strobes;
    xfer(8'h4A, 8'h9D, 1, 8'h00, a1, a2, a3);
    chk("R3 code id ack", a1, 0);
    chk("R3 code instr ack", a2, 0);
    chk("R3 code data ack", a3, 0);
    xfer(8'h5B, 8'h9D, 0, 8'h00, a1, a2, a3);
    chk("R3 addr id ack", a1, 0);
    chk("R3 addr instr ack", a2, 0);
    chk("R3 strobes", strobes - s0, 0);

    // random transfers
    for (int it = 0; it < 20; it++) begin
      logic [7:0] id, ins;
      bit ok;
      pins = 4'($urandom);
      id   = ($urandom % 2) ? {4'b0101, pins} : 8'($urandom);
      ins  = 8'($urandom);
      if (ins[7:4] == 4'hC) ins[7:4] = 4'h3;
      ok = f_id_ok(id, pins);
      s0 = strobes;
      xfer(id, ins, 1, 8'($urandom), a1, a2, a3);
      chk("R2/R3 rand id ack", a1, ok);
      chk("R5 rand data ack", a3, ok);
      chk("R4 rand strobe", strobes - s0, ok);
      if (ok) begin
        chk("R4 rand op", last_op, ins[7:4]);
        chk("R4 rand reg", last_reg, ins[3:2]);
        chk("R4 rand wiper", last_wiper, ins[0]);
      end
      chk("R9 rand busy", busy, 0);
    end

    pins = 4'h6;
    // NV opcode without data byte
    xfer(8'h56, 8'hC4, 0, 8'h00, a1, a2, a3);
    wq(20);
    chk("R9 nv no data", busy, 0);

    // abort mid instruction byte
    s0 = strobes;
    bus_start;
    send_byte(8'h56, a1);
    send_bits(8'h9D, 4);
    scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); sda_m = 1'b1; wq(Q);
    wq(20);
    chk("R8 no strobe", strobes - s0, 0);
    // abort mid data byte of NV write
    bus_start;
    send_byte(8'h56, a1);
    send_byte(8'hC1, a2);
    send_bits(8'hF0, 3);
    scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); sda_m = 1'b1; wq(Q);
    wq(20);
    chk("R8 no busy", busy, 0);
    chk("R8 no busy rise", busy_rises, 0);

    // qualifying NV write and polling
    xfer(8'h56, 8'hC5, 1, 8'h7F, a1, a2, a3);
    chk("R6 nv data ack", a3, 1);
    wq(4);
    chk("R6 busy raised", busy, 1);
    s0 = strobes;
    bus_start;
    send_byte(8'h56, a1);
    send_byte(8'h9D, a2);
    bus_stop;
    chk("R7 poll nack", a1, 0);
    chk("R7 no strobe busy", strobes - s0, 0);
    while (busy) wq(1);
    wq(2);
    chk("R6 busy length", busy_last, WR);
    chk("R6 single window", busy_rises, 1);
    xfer(8'h56, 8'h11, 0, 8'h00, a1, a2, a3);
    chk("R7 poll ack", a1, 1);
    chk("R7 strobe after", strobes - s0, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule